// File: doc/BRIEF.md
# Test Tone Injector with Stepped Gain

This block sits in the transmit data stream of a multi-channel radio datapath. When the tone is off, every channel's I/Q sample beat goes through unchanged. When the tone is on, every beat is replaced by a locally generated complex tone. All channels carry the same tone. The tone is set by a signed tuning word, so it can sit above or below the carrier. A 2-bit code sets its level in 6 dB steps.

A 32-bit phase register advances by the tuning word once for each accepted beat. The top 10 phase bits address a sine/cosine lookup. That lookup is built from a quarter-wave table that the block computes itself during elaboration. The level step is an arithmetic right shift.

Both stream sides use valid/ready. A beat is taken when `s_valid` and `s_ready` are both high. The output holds a single registered beat. `s_ready` is high when that register is empty or is being drained in the same cycle. While `m_valid` is high and `m_ready` is low, the output beat stays frozen. Mode, tuning word and gain are sampled in the cycle a beat is accepted.

Top module: `tone_inject`

## Requirements
- R1: During and after reset, `m_valid` is 0 and `s_ready` is 1 until a beat is accepted.
- R2: With `tone_en` low, an accepted beat appears on `m_data` one cycle later, bit for bit unchanged.
- R3: With `tone_en` high, every channel lane carries the same tone sample. Lane c occupies bits [32c+31:32c], with I (sine) in the low 16 bits and Q (cosine) in the high 16 bits. For a 10-bit phase index p, the full-scale I value is within 2 LSB of round(32767*sin(2*pi*(p+0.5)/1024)). Q uses the same expression at index (p+256) mod 1024.
- R4: The phase register adds the signed tuning word, modulo 2^32, once per accepted tone beat, and never otherwise. A negative word reverses the I/Q rotation.
- R5: Gain codes 0, 1, 2 and 3 select -18, -12, -6 and 0 dB. The full-scale sample is shifted right arithmetically by 3, 2, 1 and 0 bits respectively.
- R6: With `tone_gain_use` low, the code on `tone_gain` has no effect and the tone is at full scale.
- R7: A cycle in which `tone_en` is high after being low in the previous cycle clears the phase. The first tone beat accepted from then on uses phase 0, whether it is accepted in that same cycle or later.
- R8: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` holds its value. No beat is lost, and beats leave in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tone_en | input | 1 | Replace channel data with the tone |
| tone_fword | input | 32 | Signed phase increment per beat |
| tone_gain | input | 2 | Level code, 6 dB per step |
| tone_gain_use | input | 1 | Apply `tone_gain`; when low, full scale |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high with `s_valid` |
| s_data | input | 128 | Four lanes of {Q,I} 16-bit samples |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream accepts output beat |
| m_data | output | 128 | Four lanes of {Q,I} 16-bit samples |

## Verification
The hardest case to reach from the ports is an enable edge that falls in a cycle with no accepted beat, or one that coincides with a stalled input beat. In both cases the phase must still restart at zero for the next tone beat. The stimulus toggles `tone_en` on short runs while input valid and output ready are drawn at random, including stretches with no valid input and stretches of heavy back-pressure. A behavioural model compares the output beat in every cycle, and it evaluates enable edges and the sampling of mode and tuning word at acceptance independently of the design.

// File: rtl/tone_pkg.sv
package tone_pkg;

  typedef enum logic [1:0] {
    LVL_M18 = 2'd0,
    LVL_M12 = 2'd1,
    LVL_M6  = 2'd2,
    LVL_0   = 2'd3
  } tone_level_e;

  // Each 6 dB step below full scale is one bit of arithmetic shift
  function automatic logic [1:0] level_to_shift(input logic [1:0] code, input logic use_code);
    if (!use_code) return 2'd0;
    return 2'd3 - code;
  endfunction

endpackage

// File: rtl/tone_phase_acc.sv
module tone_phase_acc #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               adv,
  input  logic [PHASE_W-1:0] fword,
  output logic [PHASE_W-1:0] phase_cur
);

  logic [PHASE_W-1:0] ph_q;

  // A clear takes effect for a beat accepted in the same cycle
  assign phase_cur = clear ? '0 : ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else if (clear || adv) begin
      ph_q <= adv ? phase_cur + fword : phase_cur;
    end
  end

endmodule

// File: rtl/tone_quarter_lut.sv
module tone_quarter_lut #(
  parameter int SAMP_W = 16,
  parameter int IDX_W  = 10
) (
  input  logic [IDX_W-1:0]         idx,
  output logic signed [SAMP_W-1:0] val
);

  localparam int QBITS  = IDX_W - 2;
  localparam int QDEPTH = 1 << QBITS;
  localparam int FX     = 30;
  localparam longint PI_FX = 64'sd3373259426;

  // Sine of the centre of each quarter-wave bin, integer Taylor series
  function automatic logic [QDEPTH*SAMP_W-1:0] build_quarter();
    logic [QDEPTH*SAMP_W-1:0] tab;
    longint x, x2, term, acc, amp, ent;
    tab = '0;
    amp = (64'sd1 <<< (SAMP_W - 1)) - 64'sd1;
    for (int k = 0; k < QDEPTH; k++) begin
      x    = (PI_FX * longint'(2 * k + 1)) / longint'(4 * QDEPTH);
      x2   = (x * x) >>> FX;
      term = x;
      acc  = x;
      for (int n = 1; n <= 8; n++) begin
        term = (term * x2) >>> FX;
        term = -term / longint'((2 * n) * (2 * n + 1));
        acc  = acc + term;
      end
      ent = (acc * amp + (64'sd1 <<< (FX - 1))) >>> FX;
      if (ent > amp) ent = amp;
      if (ent < 0) ent = 0;
      tab[k*SAMP_W +: SAMP_W] = ent[SAMP_W-1:0];
    end
    return tab;
  endfunction

  localparam logic [QDEPTH*SAMP_W-1:0] QTAB = build_quarter();

  logic [QBITS-1:0]         addr;
  logic signed [SAMP_W-1:0] mag;

  // Odd quadrants read the table backwards; the upper half is negated
  assign addr = idx[IDX_W-2] ? ~idx[QBITS-1:0] : idx[QBITS-1:0];
  assign mag  = QTAB[int'(addr)*SAMP_W +: SAMP_W];
  assign val  = idx[IDX_W-1] ? -mag : mag;

endmodule

// File: rtl/tone_gain_step.sv
module tone_gain_step #(
  parameter int SAMP_W = 16
) (
  input  logic signed [SAMP_W-1:0] x,
  input  logic [1:0]               sh,
  output logic signed [SAMP_W-1:0] y
);

  assign y = x >>> sh;

endmodule

// File: rtl/tone_inject.sv
module tone_inject
  import tone_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int SAMP_W  = 16,
  parameter int PHASE_W = 32,
  parameter int IDX_W   = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tone_en,
  input  logic signed [PHASE_W-1:0]     tone_fword,
  input  logic [1:0]                    tone_gain,
  input  logic                          tone_gain_use,
  input  logic                          s_valid,
  output logic                          s_ready,
  input  logic [NUM_CH*2*SAMP_W-1:0]    s_data,
  output logic                          m_valid,
  input  logic                          m_ready,
  output logic [NUM_CH*2*SAMP_W-1:0]    m_data
);

  localparam int LANE_W = 2 * SAMP_W;
  localparam int BUS_W  = NUM_CH * LANE_W;
  localparam logic [IDX_W-1:0] QUARTER = IDX_W'(1 << (IDX_W - 2));

  logic               en_q;
  logic               en_rise;
  logic               beat;
  logic [PHASE_W-1:0] phase_cur;
  logic [IDX_W-1:0]   idx_sin, idx_cos;
  logic signed [SAMP_W-1:0] raw [2];
  logic signed [SAMP_W-1:0] lvl [2];
  logic [1:0]         shift;
  logic [BUS_W-1:0]   tone_bus;
  logic               unused_low;

  assign s_ready = !m_valid || m_ready;
  assign beat    = s_valid && s_ready;
  assign en_rise = tone_en && !en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= tone_en;
  end

  tone_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (en_rise),
    .adv      (beat && tone_en),
    .fword    (tone_fword),
    .phase_cur(phase_cur)
  );

  assign idx_sin    = phase_cur[PHASE_W-1 -: IDX_W];
  assign idx_cos    = idx_sin + QUARTER;
  assign unused_low = ^phase_cur[PHASE_W-IDX_W-1:0];
  assign shift      = level_to_shift(tone_gain, tone_gain_use);

  // Index 0 is the sine (I), index 1 the cosine (Q)
  for (genvar g = 0; g < 2; g++) begin : g_comp
    tone_quarter_lut #(.SAMP_W(SAMP_W), .IDX_W(IDX_W)) u_lut (
      .idx(g == 0 ? idx_sin : idx_cos),
      .val(raw[g])
    );
    tone_gain_step #(.SAMP_W(SAMP_W)) u_gain (
      .x (raw[g]),
      .sh(shift),
      .y (lvl[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    assign tone_bus[c*LANE_W +: LANE_W] = {lvl[1], lvl[0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (beat) begin
      m_valid <= 1'b1;
      m_data  <= tone_en ? tone_bus : s_data;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/tone_inject_chk.sv
module tone_inject_chk #(
  parameter int NUM_CH  = 4,
  parameter int SAMP_W  = 16,
  parameter int PHASE_W = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       tone_en,
  input logic [PHASE_W-1:0]         tone_fword,
  input logic                       s_valid,
  input logic                       s_ready,
  input logic [NUM_CH*2*SAMP_W-1:0] s_data,
  input logic                       m_valid,
  input logic                       m_ready,
  input logic [NUM_CH*2*SAMP_W-1:0] m_data,
  input logic                       en_q,
  input logic [PHASE_W-1:0]         phase_cur
);

  localparam int LANE_W = 2 * SAMP_W;
  localparam int BUS_W  = NUM_CH * LANE_W;

  function automatic logic lanes_match(input logic [BUS_W-1:0] d);
    for (int c = 1; c < NUM_CH; c++) begin
      if (d[c*LANE_W +: LANE_W] != d[LANE_W-1:0]) return 1'b0;
    end
    return 1'b1;
  endfunction

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));  // R8

  AST_BEAT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> m_valid);  // R8

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!tone_en && s_valid && s_ready) |=> (m_data == $past(s_data)));  // R2

  AST_LANES_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_en && s_valid && s_ready) |=> lanes_match(m_data));  // R3

  AST_RISE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_en && !en_q && !(s_valid && s_ready)) |=> (phase_cur == '0));  // R7

  AST_RISE_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_en && !en_q && s_valid && s_ready) |=> (phase_cur == $past(tone_fword)));  // R7

endmodule

bind tone_inject tone_inject_chk #(
  .NUM_CH (NUM_CH),
  .SAMP_W (SAMP_W),
  .PHASE_W(PHASE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tone_en   (tone_en),
  .tone_fword(tone_fword),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .s_data    (s_data),
  .m_valid   (m_valid),
  .m_ready   (m_ready),
  .m_data    (m_data),
  .en_q      (en_q),
  .phase_cur (phase_cur)
);

// File: tb/tb_tone_inject.sv
module tb_tone_inject;

  localparam int NCH = 4;
  localparam int BW  = NCH * 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tone_en = 1'b0;
  logic signed [31:0] tone_fword = '0;
  logic [1:0]        tone_gain = 2'd3;
  logic              tone_gain_use = 1'b0;
  logic              s_valid = 1'b0;
  logic              s_ready;
  logic [BW-1:0]     s_data = '0;
  logic              m_valid;
  logic              m_ready = 1'b0;
  logic [BW-1:0]     m_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit hold_in = 0;

  // Reference model state
  longint    mph = 0;
  bit        men_q = 0;
  logic [BW-1:0] exp_q[$];
  bit        tone_q[$];
  string     tag_q[$];

  always #2 clk = ~clk;

  tone_inject dut (
    .clk(clk), .rst_n(rst_n), .tone_en(tone_en), .tone_fword(tone_fword),
    .tone_gain(tone_gain), .tone_gain_use(tone_gain_use),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int tone_val(input longint ph, input bit cosine, input int sh);
    int p;
    real r;
    int v;
    p = int'((ph >> 22) & 64'h3FF);
    if (cosine) p = (p + 256) % 1024;
    r = 32767.0 * $sin(6.283185307179586 * (real'(p) + 0.5) / 1024.0);
    v = (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
    return v >>> sh;
  endfunction

  // Monitor and model, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit front;
      front = (exp_q.size() > 0);
      check(m_valid == front, "R8", "m_valid", longint'(m_valid), longint'(front));
      check(s_ready == (!front || m_ready), "R8", "s_ready", longint'(s_ready),
            longint'(!front || m_ready));
      if (m_valid && front) begin
        for (int c = 0; c < NCH; c++) begin
          for (int h = 0; h < 2; h++) begin
            int a, e, d;
            a = int'($signed(m_data[c*32 + h*16 +: 16]));
            e = int'($signed(exp_q[0][c*32 + h*16 +: 16]));
            d = (a > e) ? a - e : e - a;
            check(d <= (tone_q[0] ? 2 : 0), tag_q[0], "lane sample", longint'(a), longint'(e));
          end
        end
        if (m_ready) begin
          void'(exp_q.pop_front());
          void'(tone_q.pop_front());
          void'(tag_q.pop_front());
        end
      end
      begin
        bit rise;
        longint eff;
        int sh;
        rise = tone_en && !men_q;
        eff  = rise ? 0 : mph;
        sh   = tone_gain_use ? (3 - int'(tone_gain)) : 0;
        hold_in = s_valid && !s_ready;
        if (s_valid && s_ready) begin
          logic [BW-1:0] e;
          string t;
          if (tone_en) begin
            int iv, qv;
            iv = tone_val(eff, 1'b0, sh);
            qv = tone_val(eff, 1'b1, sh);
            for (int c = 0; c < NCH; c++) e[c*32 +: 32] = {16'(qv), 16'(iv)};
            if (rise)                t = "R7";
            else if (tone_fword < 0) t = "R4";
            else if (!tone_gain_use) t = "R6";
            else if (sh != 0)        t = "R5";
            else                     t = "R3";
            mph = (eff + longint'(tone_fword)) & 64'hFFFF_FFFF;
          end else begin
            e = s_data;
            t = "R2";
            mph = eff;
          end
          exp_q.push_back(e);
          tone_q.push_back(tone_en);
          tag_q.push_back(t);
        end else begin
          mph = eff;
        end
        men_q = tone_en;
      end
    end
  end

  task automatic run(input int cyc, input bit en, input logic signed [31:0] fw,
                     input logic [1:0] g, input bit gu, input int vp, input int rp);
    for (int i = 0; i < cyc; i++) begin
      @(posedge clk);
      #1;
      tone_en = en;
      tone_fword = fw;
      tone_gain = g;
      tone_gain_use = gu;
      if (!hold_in) begin
        s_valid = ($urandom % 100) < vp;
        s_data  = {$urandom, $urandom, $urandom, $urandom};
      end
      m_ready = ($urandom % 100) < rp;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(m_valid == 1'b0, "R1", "m_valid in reset", longint'(m_valid), 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(m_valid == 1'b0, "R1", "m_valid after reset", longint'(m_valid), 0);
    check(s_ready == 1'b1, "R1", "s_ready after reset", longint'(s_ready), 1);

    run(40, 0, 32'sd0, 2'd3, 1'b1, 70, 70);                 // R2 pass-through
    run(60, 1, 32'sh0123_4567, 2'd0, 1'b0, 80, 60);         // R6 gain ignored, R7 start
    run(10, 0, 32'sd0, 2'd3, 1'b1, 60, 100);
    run(60, 1, 32'sh0400_0000, 2'd3, 1'b1, 100, 100);       // R3 full sweep
    for (int g = 0; g < 3; g++) begin                       // R5 each level
      run(6, 0, 32'sd0, 2'd3, 1'b1, 50, 100);
      run(40, 1, 32'sh0321_0000, 2'(g), 1'b1, 80, 70);
    end
    run(5, 0, 32'sd0, 2'd3, 1'b1, 50, 100);
    run(80, 1, -32'sh0234_5678, 2'd3, 1'b1, 90, 50);        // R4 negative word
    run(3, 0, 32'sd0, 2'd3, 1'b1, 0, 100);
    run(5, 1, 32'sh0111_0000, 2'd3, 1'b1, 0, 100);          // R7 rise with no beat
    run(30, 1, 32'sh0111_0000, 2'd3, 1'b1, 80, 80);
    run(3, 0, 32'sd0, 2'd3, 1'b1, 100, 100);
    run(20, 1, 32'sd0, 2'd3, 1'b1, 100, 100);               // R7 phase zero held
    run(60, 1, 32'sh1357_9bdf, 2'd2, 1'b1, 90, 20);         // R8 back-pressure
    for (int k = 0; k < 24; k++) begin                      // R7 rapid toggling
      run(2, k[0], 32'sh0765_4321, 2'd1, 1'b1, 85, 40);
    end
    run(30, 0, 32'sd0, 2'd3, 1'b1, 70, 50);
    run(12, 0, 32'sd0, 2'd3, 1'b1, 0, 100);
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

endmodule